// File: doc/BRIEF.md
# Supply-Loss Access Guard for a Battery-Backed Byte Memory

This block sits between a host's active-low memory strobes and a 2K x 8 static array that is kept alive by a backup cell. It reads three digital results from external comparators: the supply is below the deselect level, the supply is below the backup-switchover level, and the backup cell is weak. From these and the raw chip-enable, output-enable and write-enable, it produces the strobes the array actually sees and the enable for the data pin drivers.

A three-state machine sets the access policy. `ST_OFF` blocks everything while the supply is low. `ST_HOLD` keeps the array blocked for a programmable recovery count after the supply returns. `ST_LIVE` passes host accesses through. The transitions are: any state to `ST_OFF` when the supply-low input is sampled high; `ST_OFF` to `ST_HOLD` when it is sampled low; `ST_HOLD` to `ST_LIVE` once the recovery count has elapsed. A separate sticky weak-cell flag is sampled when the supply climbs back through the switchover level. While the flag is set, the next write from the host is silently dropped. The flag then clears itself, and the write after that reaches the array.

Top module: `pwr_guard_top`

## Requirements
- R1: Any clock edge that samples `sup_low` high puts the block into `ST_OFF` by the next cycle. In `ST_OFF`, `arr_ce_n`=1, `arr_we_n`=1 and `dq_oe`=0, whatever the host strobes do.
- R2: When `sup_low` is first sampled low, the block enters `ST_HOLD`, which lasts exactly `REC_CYCLES` clocks. Access first becomes possible after `REC_CYCLES`+1 edges have sampled `sup_low` low.
- R3: The flag `batt_nok` takes the value of `batt_low` on the edge where `sup_below_sw` is first sampled low after having been high.
- R4: While `batt_nok`=1, `arr_we_n` stays 1 and `arr_ce_n` still follows the host. The blocked write does not reach the array.
- R5: `batt_nok` clears on the first edge after a write attempt ends. A write attempt is `ST_LIVE` with `ce_n`=0 and `we_n`=0. The next write then drives `arr_we_n`=0.
- R6: `dq_oe`=1 only in `ST_LIVE` with `ce_n`=0, `oe_n`=0 and `we_n`=1.
- R7: With `ce_n`=1, `arr_ce_n`=1, `arr_we_n`=1 and `dq_oe`=0.
- R8: If `sup_low` rises during a write, `arr_we_n` stays low until the next edge, goes high on that edge, and no further write strobe is issued while `sup_low` remains high.
- R9: During reset the block is in `ST_OFF` with `batt_nok`=0 and all array strobes inactive.
- R10: Changes on `batt_low` while `sup_below_sw` does not cross the threshold leave `batt_nok` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Host chip enable, active low |
| oe_n | input | 1 | Host output enable, active low |
| we_n | input | 1 | Host write enable, active low |
| sup_low | input | 1 | Supply is below the deselect level |
| sup_below_sw | input | 1 | Supply is below the backup-switchover level |
| batt_low | input | 1 | Backup cell voltage is weak |
| arr_ce_n | output | 1 | Gated chip enable to the array |
| arr_we_n | output | 1 | Gated write strobe to the array |
| dq_oe | output | 1 | Enable for the data pin drivers |
| batt_nok | output | 1 | Sticky weak-cell flag, read-only |

## Verification
The gated strobes are combinational from the registered state, so a host strobe change is checked one nanosecond after it is driven, inside the same cycle. A `sup_low` change takes effect one edge later: the blocked outputs are checked after one negative edge, and the open-up point is checked after exactly `REC_CYCLES` edges and again after `REC_CYCLES`+1. The flag samples one edge after the threshold crossing and clears one edge after the write ends, so each flag check sits at the negative edge that follows that register. Inputs change only just after a negative edge, so no check races a rising edge.

// File: rtl/pfg_pkg.sv
package pfg_pkg;
    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_HOLD = 2'd1,
        ST_LIVE = 2'd2
    } pfg_state_e;
endpackage

// File: rtl/pfg_seq.sv
module pfg_seq #(
    parameter int REC_CYCLES = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sup_low,
    output logic live,
    output logic hold
);
    import pfg_pkg::*;

    localparam int CW = (REC_CYCLES < 2) ? 1 : $clog2(REC_CYCLES);
    localparam logic [CW-1:0] LAST = CW'(REC_CYCLES - 1);

    pfg_state_e state_q, state_d;
    logic [CW-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_OFF: begin
                cnt_d = '0;
                if (!sup_low) state_d = ST_HOLD;
            end
            ST_HOLD: begin
                if (sup_low) begin
                    state_d = ST_OFF;
                    cnt_d   = '0;
                end else if (cnt_q == LAST) begin
                    state_d = ST_LIVE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
            ST_LIVE: begin
                if (sup_low) state_d = ST_OFF;
            end
            default: state_d = ST_OFF;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Outputs
    always_comb begin
        live = 1'b0;
        hold = 1'b0;
        unique case (state_q)
            ST_OFF:  ;
            ST_HOLD: hold = 1'b1;
            ST_LIVE: live = 1'b1;
            default: ;
        endcase
    end

    p_off_on_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
        sup_low |=> !live && !hold);
    p_live_after_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(live) |-> $past(hold));
endmodule

// File: rtl/pfg_batt.sv
module pfg_batt (
    input  logic clk,
    input  logic rst_n,
    input  logic below_sw,
    input  logic batt_low,
    input  logic wr_try,
    output logic nok
);
    logic sw_q, wr_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sw_q <= 1'b1;
            wr_q <= 1'b0;
            nok  <= 1'b0;
        end else begin
            sw_q <= below_sw;
            wr_q <= wr_try;
            if (sw_q && !below_sw)
                nok <= batt_low;
            else if (wr_q && !wr_try)
                nok <= 1'b0;
        end
    end

    p_set_needs_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nok) |-> $past(batt_low));
endmodule

// File: rtl/pfg_gate.sv
module pfg_gate (
    input  logic live,
    input  logic nok,
    input  logic ce_n,
    input  logic oe_n,
    input  logic we_n,
    output logic arr_ce_n,
    output logic arr_we_n,
    output logic dq_oe,
    output logic wr_try
);
    logic sel;

    always_comb begin
        sel      = live && !ce_n;
        wr_try   = sel && !we_n;
        arr_ce_n = !sel;
        arr_we_n = !(wr_try && !nok);
        dq_oe    = sel && !oe_n && we_n;
    end
endmodule

// File: rtl/pwr_guard_top.sv
module pwr_guard_top #(
    parameter int REC_CYCLES = 100000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic oe_n,
    input  logic we_n,
    input  logic sup_low,
    input  logic sup_below_sw,
    input  logic batt_low,
    output logic arr_ce_n,
    output logic arr_we_n,
    output logic dq_oe,
    output logic batt_nok
);
    logic live, hold, wr_try;

    pfg_seq #(.REC_CYCLES(REC_CYCLES)) u_seq (
        .clk(clk), .rst_n(rst_n), .sup_low(sup_low), .live(live), .hold(hold)
    );

    pfg_batt u_batt (
        .clk(clk), .rst_n(rst_n), .below_sw(sup_below_sw),
        .batt_low(batt_low), .wr_try(wr_try), .nok(batt_nok)
    );

    pfg_gate u_gate (
        .live(live), .nok(batt_nok), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .arr_ce_n(arr_ce_n), .arr_we_n(arr_we_n), .dq_oe(dq_oe), .wr_try(wr_try)
    );

    p_protect_r1: assert property (@(posedge clk) disable iff (!rst_n)
        sup_low |=> (arr_ce_n && arr_we_n && !dq_oe));
    p_nok_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        batt_nok |-> arr_we_n);
    p_no_drive_in_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> (arr_we_n && !arr_ce_n));
    p_deselect_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |-> (arr_ce_n && arr_we_n && !dq_oe));
endmodule

// File: tb/sim_pwr_guard_top.sv
module sim_pwr_guard_top;
    localparam int REC = 12;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic sup_low = 1'b1, sup_below_sw = 1'b1, batt_low = 1'b0;
    logic arr_ce_n, arr_we_n, dq_oe, batt_nok;
    int n_cmp = 0, n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pwr_guard_top #(.REC_CYCLES(REC)) u0 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .sup_low(sup_low), .sup_below_sw(sup_below_sw), .batt_low(batt_low),
        .arr_ce_n(arr_ce_n), .arr_we_n(arr_we_n), .dq_oe(dq_oe), .batt_nok(batt_nok)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic t_reset();
        #1;
        chk("R9 arr_ce_n in reset", int'(arr_ce_n), 1);
        chk("R9 arr_we_n in reset", int'(arr_we_n), 1);
        chk("R9 dq_oe in reset", int'(dq_oe), 0);
        chk("R9 batt_nok in reset", int'(batt_nok), 0);
    endtask

    task automatic power_up(input logic bl);
        ce_n = 1'b1; oe_n = 1'b0; we_n = 1'b1;
        sup_low = 1'b1; sup_below_sw = 1'b1; batt_low = bl;
        step();
        sup_below_sw = 1'b0;
        step(); #1;
        chk("R3 flag sampled at crossing", int'(batt_nok), int'(bl));
        ce_n = 1'b0;
        sup_low = 1'b0;
        for (int i = 0; i < REC; i++) step();
        #1;
        chk("R2 still blocked at end of hold", int'(dq_oe), 0);
        chk("R2 chip enable blocked at end of hold", int'(arr_ce_n), 1);
        step(); #1;
        chk("R2 access opens after hold", int'(dq_oe), 1);
        ce_n = 1'b1; oe_n = 1'b1;
    endtask

    task automatic t_read();
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; #1;
        chk("R6 read drives", int'(dq_oe), 1);
        oe_n = 1'b1; #1;
        chk("R6 no drive without oe", int'(dq_oe), 0);
        chk("R6 array still selected", int'(arr_ce_n), 0);
        oe_n = 1'b0; we_n = 1'b0; #1;
        chk("R6 no drive during write", int'(dq_oe), 0);
        step();
        we_n = 1'b1; ce_n = 1'b1; oe_n = 1'b1;
        step();
    endtask

    task automatic t_deselect();
        ce_n = 1'b1; oe_n = 1'b0; we_n = 1'b0; #1;
        chk("R7 arr_ce_n deselected", int'(arr_ce_n), 1);
        chk("R7 arr_we_n deselected", int'(arr_we_n), 1);
        chk("R7 dq_oe deselected", int'(dq_oe), 0);
        we_n = 1'b1; oe_n = 1'b1;
        step();
    endtask

    task automatic t_write();
        ce_n = 1'b0; we_n = 1'b0; #1;
        chk("R5 write reaches array", int'(arr_we_n), 0);
        step();
        we_n = 1'b1; ce_n = 1'b1;
        step(); #1;
        chk("R5 flag stays clear", int'(batt_nok), 0);
    endtask

    task automatic t_ignore_batt();
        batt_low = 1'b1; step(); step(); #1;
        chk("R10 flag unchanged by batt_low", int'(batt_nok), 0);
        batt_low = 1'b0; step();
    endtask

    task automatic t_abort();
        ce_n = 1'b0; we_n = 1'b0; #1;
        chk("R8 write active before fail", int'(arr_we_n), 0);
        sup_low = 1'b1; #1;
        chk("R8 strobe held until edge", int'(arr_we_n), 0);
        step(); #1;
        chk("R8 strobe cut after edge", int'(arr_we_n), 1);
        we_n = 1'b1; step();
        we_n = 1'b0; step(); #1;
        chk("R8 no new strobe while low", int'(arr_we_n), 1);
        chk("R1 chip enable blocked", int'(arr_ce_n), 1);
        we_n = 1'b1; oe_n = 1'b0; #1;
        chk("R1 read blocked", int'(dq_oe), 0);
        sup_low = 1'b0;
        for (int i = 0; i < REC + 1; i++) step();
        #1;
        chk("R2 read back after recovery", int'(dq_oe), 1);
        ce_n = 1'b1; oe_n = 1'b1;
        step();
    endtask

    task automatic t_blocked();
        power_up(1'b1);
        batt_low = 1'b0; step(); #1;
        chk("R10 set flag holds without crossing", int'(batt_nok), 1);
        ce_n = 1'b0; we_n = 1'b0; #1;
        chk("R4 first write blocked", int'(arr_we_n), 1);
        chk("R4 chip enable passes", int'(arr_ce_n), 0);
        step(); #1;
        chk("R4 still blocked during attempt", int'(arr_we_n), 1);
        chk("R4 flag set during attempt", int'(batt_nok), 1);
        we_n = 1'b1;
        step(); #1;
        chk("R5 flag cleared after attempt", int'(batt_nok), 0);
        we_n = 1'b0; #1;
        chk("R5 next write reaches array", int'(arr_we_n), 0);
        step();
        we_n = 1'b1; ce_n = 1'b1;
        step();
    endtask

    initial begin
        t_reset();
        step();
        rst_n = 1'b1;
        step(); #1;
        chk("R1 blocked after reset while supply low", int'(arr_ce_n), 1);
        power_up(1'b0);
        t_read();
        t_deselect();
        t_write();
        t_ignore_batt();
        t_abort();
        t_blocked();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule